// File: doc/BRIEF.md
# Sequential Signed Divider with Truncating and Flooring Modes

This block divides one WIDTH-bit operand by another and returns a quotient and a remainder. Each operand carries its own flag that says whether its top bit is a sign bit. A mode input chooses the rounding rule. Truncating mode rounds the quotient toward zero. Flooring mode rounds it toward minus infinity. The same iterative datapath serves both modes.

The block first takes the magnitude of each operand. It then runs a restoring shift-and-subtract loop that yields one quotient bit per clock. A final stage restores the signs and, in flooring mode, adjusts the pair by one step when the division leaves a remainder and the operands have opposite signs. A caller pulses `start` while `busy` is low. It then waits for the single-cycle `done` pulse. The results stay on the outputs until the next operation completes. A zero divisor produces a defined answer and raises a flag.

Top module: `quorem_div`

## Requirements
- R1: With `floor_mode`=0 the quotient is rounded toward zero and a non-zero remainder has the dividend's sign: -10/3 gives -3 rem -1, and 10/-3 gives -3 rem 1.
- R2: With `floor_mode`=1 the quotient is rounded toward minus infinity and a non-zero remainder has the divisor's sign: -10/3 gives -4 rem 2, and 10/-3 gives -4 rem -2.
- R3: When both operands have the same sign, both modes give the same pair: -10/-3 gives 3 rem -1, and 10/3 gives 3 rem 1.
- R4: An operand whose signed flag is 1 is read as two's complement. An operand whose flag is 0 is read as a non-negative value, even when its top bit is 1, and is never negated.
- R5: The flooring adjustment (quotient minus 1, remainder plus divisor) is applied only when the truncated remainder is non-zero and the operand signs differ. For example, -9/3 in flooring mode gives -3 rem 0.
- R6: A `start` accepted while `busy` is low causes `busy` to rise on the next cycle. `done` is raised exactly WIDTH+2 cycles after the accepting clock edge.
- R7: `done` is high for exactly one cycle. `quotient`, `remainder` and `div_zero` change only on that cycle and hold their values until the next completion.
- R8: A `start` pulse while `busy` is high is ignored. It produces no extra completion and does not disturb the operation in flight.
- R9: A zero divisor sets `div_zero`, returns a quotient of all ones and returns the raw dividend as the remainder, in either mode. Any other divisor clears `div_zero`.
- R10: After reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all 0.
- R11: Each result is the low WIDTH bits of the exact value. The most negative signed number divided by signed -1 returns the most negative number, with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; taken only while busy is low |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| dividend_signed | input | 1 | 1: dividend is two's complement |
| divisor_signed | input | 1 | 1: divisor is two's complement |
| floor_mode | input | 1 | 0: truncating, 1: flooring |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| quotient | output | WIDTH | Quotient, low WIDTH bits |
| remainder | output | WIDTH | Remainder, low WIDTH bits |
| div_zero | output | 1 | The last completed operation had a zero divisor |

## Verification
Every result is due WIDTH+2 cycles after the edge that accepts `start`. That is one preparation cycle, WIDTH iteration cycles and one correction cycle. The driver stamps each expected item with the edge number of its accepting edge. The monitor samples on falling edges, pops an item on each `done` and checks the cycle count as well as the values. A `done` with nothing queued, or two `done` cycles in a row, counts as a failure. After an idle gap, the bench reads the held outputs again to confirm that they did not move.

// File: rtl/quorem_pkg.sv
package quorem_pkg;

    // Controller phases: accept, prepare magnitudes, iterate, correct.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_ITER = 2'd2,
        ST_FIX  = 2'd3
    } qd_state_e;

    // Sign and mode information carried from preparation to correction.
    typedef struct packed {
        logic dvd_neg;
        logic dvs_neg;
        logic floor_m;
        logic zero_dvs;
    } qd_sign_t;

    // Flooring adjustment: only for a non-zero remainder with opposite signs.
    function automatic logic needs_floor_fix(qd_sign_t s, logic rem_nz);
        return s.floor_m & rem_nz & (s.dvd_neg ^ s.dvs_neg) & ~s.zero_dvs;
    endfunction

    // Quotient is negative whenever exactly one operand is negative.
    function automatic logic quot_negative(qd_sign_t s);
        return s.dvd_neg ^ s.dvs_neg;
    endfunction

endpackage

// File: rtl/quorem_prep.sv
module quorem_prep
    import quorem_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] dvd_raw,
    input  logic [WIDTH-1:0] dvs_raw,
    input  logic             dvd_is_signed,
    input  logic             dvs_is_signed,
    input  logic             floor_sel,
    output logic [WIDTH-1:0] dvd_mag,
    output logic [WIDTH-1:0] dvs_mag,
    output qd_sign_t         info
);
    localparam int MSB = WIDTH - 1;

    logic dvd_neg_w;
    logic dvs_neg_w;

    // An unsigned operand is never treated as negative.
    assign dvd_neg_w = dvd_is_signed & dvd_raw[MSB];
    assign dvs_neg_w = dvs_is_signed & dvs_raw[MSB];

    assign dvd_mag = dvd_neg_w ? (~dvd_raw + 1'b1) : dvd_raw;
    assign dvs_mag = dvs_neg_w ? (~dvs_raw + 1'b1) : dvs_raw;

    always_comb begin
        info          = '0;
        info.dvd_neg  = dvd_neg_w;
        info.dvs_neg  = dvs_neg_w;
        info.floor_m  = floor_sel;
        info.zero_dvs = (dvs_raw == '0);
    end
endmodule

// File: rtl/quorem_iter.sv
module quorem_iter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] dvd_mag,
    input  logic [WIDTH-1:0] dvs_mag,
    output logic [WIDTH-1:0] q_mag,
    output logic [WIDTH-1:0] r_mag
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] acc_r;
    logic [WIDTH:0]   trial;
    logic             borrow;

    // Shift the next dividend bit into the partial remainder and try the subtract.
    assign trial  = {acc_r, acc_q[MSB]} - {1'b0, dvs_mag};
    assign borrow = trial[WIDTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            acc_r <= '0;
        end else if (load) begin
            acc_q <= dvd_mag;
            acc_r <= '0;
        end else if (step) begin
            if (!borrow) begin
                acc_r <= trial[WIDTH-1:0];
                acc_q <= {acc_q[MSB-1:0], 1'b1};
            end else begin
                acc_r <= {acc_r[MSB-1:0], acc_q[MSB]};
                acc_q <= {acc_q[MSB-1:0], 1'b0};
            end
        end
    end

    assign q_mag = acc_q;
    assign r_mag = acc_r;
endmodule

// File: rtl/quorem_fix.sv
module quorem_fix
    import quorem_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] q_mag,
    input  logic [WIDTH-1:0] r_mag,
    input  qd_sign_t         info,
    input  logic [WIDTH-1:0] dvd_raw,
    input  logic [WIDTH-1:0] dvs_raw,
    output logic [WIDTH-1:0] q_out,
    output logic [WIDTH-1:0] r_out,
    output logic             zero_flag
);
    logic [WIDTH-1:0] q_trunc;
    logic [WIDTH-1:0] r_trunc;
    logic             adjust;

    assign q_trunc = quot_negative(info) ? (~q_mag + 1'b1) : q_mag;
    assign r_trunc = info.dvd_neg ? (~r_mag + 1'b1) : r_mag;
    assign adjust  = needs_floor_fix(info, |r_mag);

    always_comb begin
        if (info.zero_dvs) begin
            q_out = '1;
            r_out = dvd_raw;
        end else if (adjust) begin
            q_out = q_trunc - 1'b1;
            r_out = r_trunc + dvs_raw;
        end else begin
            q_out = q_trunc;
            r_out = r_trunc;
        end
    end

    assign zero_flag = info.zero_dvs;
endmodule

// File: rtl/quorem_div.sv
module quorem_div
    import quorem_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    input  logic             dividend_signed,
    input  logic             divisor_signed,
    input  logic             floor_mode,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             div_zero
);
    localparam int              CW        = $clog2(WIDTH + 1);
    localparam logic [CW-1:0]   LAST_STEP = CW'(WIDTH - 1);

    qd_state_e        state;
    logic [CW-1:0]    step_cnt;
    logic [WIDTH-1:0] op_dvd;
    logic [WIDTH-1:0] op_dvs;
    logic             op_dvd_s;
    logic             op_dvs_s;
    logic             op_floor;

    logic [WIDTH-1:0] dvd_mag;
    logic [WIDTH-1:0] dvs_mag;
    qd_sign_t         info;
    logic [WIDTH-1:0] q_mag;
    logic [WIDTH-1:0] r_mag;
    logic [WIDTH-1:0] q_fin;
    logic [WIDTH-1:0] r_fin;
    logic             z_fin;

    quorem_prep #(.WIDTH(WIDTH)) u_prep (
        .dvd_raw       (op_dvd),
        .dvs_raw       (op_dvs),
        .dvd_is_signed (op_dvd_s),
        .dvs_is_signed (op_dvs_s),
        .floor_sel     (op_floor),
        .dvd_mag       (dvd_mag),
        .dvs_mag       (dvs_mag),
        .info          (info)
    );

    quorem_iter #(.WIDTH(WIDTH)) u_iter (
        .clk     (clk),
        .rst     (rst),
        .load    (state == ST_PREP),
        .step    (state == ST_ITER),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .q_mag   (q_mag),
        .r_mag   (r_mag)
    );

    quorem_fix #(.WIDTH(WIDTH)) u_fix (
        .q_mag     (q_mag),
        .r_mag     (r_mag),
        .info      (info),
        .dvd_raw   (op_dvd),
        .dvs_raw   (op_dvs),
        .q_out     (q_fin),
        .r_out     (r_fin),
        .zero_flag (z_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step_cnt  <= '0;
            op_dvd    <= '0;
            op_dvs    <= '0;
            op_dvd_s  <= 1'b0;
            op_dvs_s  <= 1'b0;
            op_floor  <= 1'b0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_dvd   <= dividend;
                        op_dvs   <= divisor;
                        op_dvd_s <= dividend_signed;
                        op_dvs_s <= divisor_signed;
                        op_floor <= floor_mode;
                        state    <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    step_cnt <= '0;
                    state    <= ST_ITER;
                end
                ST_ITER: begin
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == LAST_STEP) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    quotient  <= q_fin;
                    remainder <= r_fin;
                    div_zero  <= z_fin;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/quorem_div_chk.sv
module quorem_div_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [WIDTH-1:0] dividend,
    input logic [WIDTH-1:0] divisor,
    input logic             dividend_signed,
    input logic             divisor_signed,
    input logic             floor_mode,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic [WIDTH-1:0] remainder,
    input logic             div_zero
);
    localparam int MSB = WIDTH - 1;

    logic             accept;
    int unsigned      lat_cnt;
    logic [WIDTH-1:0] cap_dvd;
    logic [WIDTH-1:0] cap_dvs;
    logic             cap_dvd_s;
    logic             cap_dvs_s;
    logic             cap_floor;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt   <= 0;
            cap_dvd   <= '0;
            cap_dvs   <= '0;
            cap_dvd_s <= 1'b0;
            cap_dvs_s <= 1'b0;
            cap_floor <= 1'b0;
        end else if (accept) begin
            lat_cnt   <= 0;
            cap_dvd   <= dividend;
            cap_dvs   <= divisor;
            cap_dvd_s <= dividend_signed;
            cap_dvs_s <= divisor_signed;
            cap_floor <= floor_mode;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    a_r6_busy_follows_start: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == WIDTH + 2));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_results_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

    a_r9_zero_divisor: assert property (@(posedge clk) disable iff (rst)
        (done && div_zero) |-> (quotient == '1 && remainder == cap_dvd && cap_dvs == '0));

    a_r1_trunc_rem_sign: assert property (@(posedge clk) disable iff (rst)
        (done && !div_zero && !cap_floor && cap_dvd_s && remainder != '0)
            |-> (remainder[MSB] == cap_dvd[MSB]));

    a_r2_floor_rem_sign: assert property (@(posedge clk) disable iff (rst)
        (done && !div_zero && cap_floor && cap_dvs_s && remainder != '0)
            |-> (remainder[MSB] == cap_dvs[MSB]));
endmodule

bind quorem_div quorem_div_chk #(.WIDTH(WIDTH)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .dividend        (dividend),
    .divisor         (divisor),
    .dividend_signed (dividend_signed),
    .divisor_signed  (divisor_signed),
    .floor_mode      (floor_mode),
    .busy            (busy),
    .done            (done),
    .quotient        (quotient),
    .remainder       (remainder),
    .div_zero        (div_zero)
);

// File: tb/quorem_div_bench.sv
module quorem_div_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         dividend_signed = 1'b0;
    logic         divisor_signed = 1'b0;
    logic         floor_mode = 1'b0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_zero;

    always #4 clk = ~clk;

    quorem_div #(.WIDTH(W)) u_quorem_div (
        .clk             (clk),
        .rst             (rst),
        .start           (start),
        .dividend        (dividend),
        .divisor         (divisor),
        .dividend_signed (dividend_signed),
        .divisor_signed  (divisor_signed),
        .floor_mode      (floor_mode),
        .busy            (busy),
        .done            (done),
        .quotient        (quotient),
        .remainder       (remainder),
        .div_zero        (div_zero)
    );

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         dz;
        longint       edge_at;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           n_tests = 0;
    int           n_fail = 0;
    int           n_issued = 0;
    int           n_done = 0;
    longint       cyc = 0;
    logic         prev_done = 1'b0;
    logic [W-1:0] last_q = '0;
    logic [W-1:0] last_r = '0;
    bit           finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Independent arithmetic model built from the requirements.
    function automatic exp_t model(input longint a, input longint b, input bit sa,
                                   input bit sb_, input bit fm, input string tag);
        exp_t   e;
        logic [W-1:0] ar;
        logic [W-1:0] br;
        longint va;
        longint vb;
        longint q;
        longint r;
        ar = a[W-1:0];
        br = b[W-1:0];
        if (sa) va = longint'($signed(ar)); else va = longint'(ar);
        if (sb_) vb = longint'($signed(br)); else vb = longint'(br);
        e.tag = tag;
        e.edge_at = 0;
        if (vb == 0) begin
            e.q  = '1;
            e.r  = ar;
            e.dz = 1'b1;
        end else begin
            q = va / vb;
            r = va % vb;
            if (fm && r != 0 && ((r < 0) != (vb < 0))) begin
                q = q - 1;
                r = r + vb;
            end
            e.q  = q[W-1:0];
            e.r  = r[W-1:0];
            e.dz = 1'b0;
        end
        return e;
    endfunction

    // Driver: called at a falling edge; waits for idle, pulses start, queues the expectation.
    task automatic issue(input longint a, input longint b, input bit sa, input bit sb_,
                         input bit fm, input string tag);
        exp_t e;
        while (busy) @(negedge clk);
        e = model(a, b, sa, sb_, fm, tag);
        e.edge_at = cyc + 1;
        dividend        = a[W-1:0];
        divisor         = b[W-1:0];
        dividend_signed = sa;
        divisor_signed  = sb_;
        floor_mode      = fm;
        start           = 1'b1;
        sb.push_back(e);
        n_issued++;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (sb.size() != 0 || busy); i++) @(negedge clk);
    endtask

    // Monitor: pops and compares on each completion.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                n_done++;
                if (sb.size() == 0) begin
                    chk(0, "R8", "unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(quotient == e.q, e.tag, "quotient", quotient, e.q);
                    chk(remainder == e.r, e.tag, "remainder", remainder, e.r);
                    chk(div_zero == e.dz, e.tag, "div_zero", div_zero, e.dz);
                    chk((cyc - e.edge_at) == W + 2, "R6", "latency",
                        cyc - e.edge_at, W + 2);
                    last_q = quotient;
                    last_r = remainder;
                end
                if (prev_done) chk(0, "R7", "done held two cycles", 1, 0);
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] lfsr;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0, "R10", "busy", busy, 0);
        chk(done == 1'b0, "R10", "done", done, 0);
        chk(div_zero == 1'b0, "R10", "div_zero", div_zero, 0);
        chk(quotient == '0, "R10", "quotient", quotient, 0);
        chk(remainder == '0, "R10", "remainder", remainder, 0);

        // R1 truncating, R2 flooring, R3 same-sign
        issue(-10, 3, 1, 1, 0, "R1");
        issue(10, -3, 1, 1, 0, "R1");
        issue(-10, 3, 1, 1, 1, "R2");
        issue(10, -3, 1, 1, 1, "R2");
        issue(-10, -3, 1, 1, 0, "R3");
        issue(-10, -3, 1, 1, 1, "R3");
        issue(10, 3, 1, 1, 0, "R3");
        issue(10, 3, 1, 1, 1, "R3");

        // R4 signedness flags
        issue(16'hFFF6, 3, 0, 1, 0, "R4");
        issue(16'hFFF6, 3, 1, 1, 0, "R4");
        issue(16'hFFF6, -3, 0, 1, 1, "R4");
        issue(-10, 16'hFFFD, 1, 0, 0, "R4");
        issue(-10, 16'hFFFD, 1, 0, 1, "R4");

        // R5 exact division with opposite signs: no flooring adjustment
        issue(-9, 3, 1, 1, 1, "R5");
        issue(9, -3, 1, 1, 1, "R5");

        // R9 zero divisor in both modes
        issue(-1234, 0, 1, 1, 0, "R9");
        issue(777, 0, 1, 0, 1, "R9");
        issue(5, 7, 1, 1, 0, "R9");

        // R11 most negative over minus one
        issue(16'h8000, -1, 1, 1, 0, "R11");
        issue(16'h8000, -1, 1, 1, 1, "R11");

        // R7 results held through an idle gap
        drain();
        repeat (6) @(negedge clk);
        chk(quotient == last_q, "R7", "held quotient", quotient, last_q);
        chk(remainder == last_r, "R7", "held remainder", remainder, last_r);

        // R8 start while busy is ignored
        issue(-100, 7, 1, 1, 1, "R8");
        chk(busy == 1'b1, "R6", "busy after start", busy, 1);
        for (int k = 0; k < 5; k++) begin
            dividend = 16'h1234;
            divisor  = 16'h0002;
            floor_mode = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
        end
        drain();
        repeat (W + 4) @(negedge clk);
        chk(sb.size() == 0, "R8", "pending items", sb.size(), 0);
        chk(n_done == n_issued, "R8", "completion count", n_done, n_issued);

        // Pseudo-random mix over all flag combinations
        lfsr = 32'hACE1_2468;
        for (int j = 0; j < 48; j++) begin
            longint a;
            longint b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = longint'(lfsr[15:0]);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = (j % 3 == 0) ? longint'(lfsr[7:0]) : longint'(lfsr[15:0]);
            issue(a, b, lfsr[17], lfsr[19], lfsr[23], (lfsr[23] ? "R2" : "R1"));
        end
        drain();
        chk(sb.size() == 0, "R6", "all results delivered", sb.size(), 0);
        finish_up();
    end
endmodule